// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a load/store pipeline and a 32-bit word-wide data bus. It accepts one access at a time: an effective address, a size code, an operation kind, store data and the attributes of the addressed storage region. Loads and stores of any alignment complete in hardware. An access that fits inside one bus word becomes one bus transaction. An access that crosses a word boundary becomes two. Each transaction carries byte enables for only the bytes the access owns. For a load, the bytes returned by the transactions are assembled into one zero-extended result.

Cache-control operations go out as a single transaction with the line offset cleared. The zero-a-line operation is the one exception: with translation off, in a region that is not cacheable or that uses write-through, it raises a one-cycle alignment exception and issues no bus transaction. The endian attribute changes only which value byte lands in which lane.

Top module: `lsu_align_split`

## Requirements
- R1: Operation codes: 0 load, 1 store, 2 cache control, 3 zero line. Size codes: 0 byte, 1 halfword, 2 word (n = 1, 2, 4 bytes). With byte offset o = addr[1:0], a load or store issues one bus transaction when o+n <= 4 and two otherwise. A load or store never raises `exc`.
- R2: The first transaction of a load or store uses the word address (addr with bits 1:0 cleared). A second transaction uses that word address plus 4. `bus_op` repeats the request's operation code.
- R3: `bus_be[k]` enables the byte at word address + k. The enables of a load or store cover exactly the access's bytes: offsets o..o+n-1 counted across the two words, in transaction order.
- R4: Byte k of a bus word sits in `bus_wdata[8k+7:8k]`. For a store, `attr_le`=1 places value byte i (from `req_wdata` bit 0 up) at address addr+i, and `attr_le`=0 places value byte n-1-i there. Lanes that are not enabled, and all lanes of non-stores, are zero.
- R5: After the last transaction, `done` pulses for exactly one cycle. For a load, `rdata` in that cycle holds the n bytes read from addr..addr+n-1, ordered as in R4 and zero-extended. For other kinds, `rdata` is zero.
- R6: `attr_le` changes neither the transaction count, the addresses, the byte enables nor the exception decision.
- R7: A cache-control operation, or a zero-line operation that does not fault, issues one transaction with address bits 3:0 cleared and `bus_be` = 0, whatever the low address bits are, and never raises `exc`.
- R8: A zero-line operation with `attr_xlate`=0 and either `attr_cacheable`=0 or `attr_wthru`=1 raises `exc` for exactly one cycle. It issues no bus transaction and no `done`.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after `done` or `exc`. While `bus_valid` is high and `bus_ready` is low, every bus output holds steady.
- R10: During and right after reset, `req_ready`=1 and `bus_valid`, `done` and `exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_op | input | 2 | Operation code (R1) |
| req_size | input | 2 | Size code (R1) |
| req_addr | input | AW | Effective address |
| req_wdata | input | 32 | Store value, right-justified |
| attr_cacheable | input | 1 | Region is cacheable |
| attr_wthru | input | 1 | Region uses write-through |
| attr_le | input | 1 | Region is little-endian |
| attr_xlate | input | 1 | Address translation enabled |
| bus_valid | output | 1 | Bus transaction offered |
| bus_ready | input | 1 | Bus accepts; read data valid this cycle |
| bus_op | output | 2 | Transaction kind, same codes as req_op |
| bus_addr | output | AW | Word or line address |
| bus_be | output | 4 | Byte enables per lane |
| bus_wdata | output | 32 | Store data by lane |
| bus_rdata | input | 32 | Read data by lane |
| done | output | 1 | Access complete pulse |
| exc | output | 1 | Alignment exception pulse |
| rdata | output | 32 | Load result, valid with done |

## Verification
The assertions assume that `req_size` never carries code 3 and that the bus side raises `bus_ready` within a bounded time, with `bus_rdata` valid in the handshake cycle. The attribute inputs are assumed meaningful only in the acceptance cycle. The stimulus draws sizes from codes 0 to 2 only. It holds `bus_ready` high three times in four at random, and the read data comes from an address-derived pattern that is always valid. Directed cases cover every offset with every size in both byte orders, cache operations at odd addresses, and all attribute combinations of the zero-line operation. Random accesses fill in the rest.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;
    localparam int BYTES = 4;
    localparam int DW    = 8 * BYTES;
    localparam int OFFW  = $clog2(BYTES);

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_CCTL  = 2'd2;
    localparam logic [1:0] OP_ZERO  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS0 = 2'd1,
        ST_BUS1 = 2'd2,
        ST_RESP = 2'd3
    } state_e;
endpackage

// File: rtl/lsu_align_decode.sv
`timescale 1ns/1ps
module lsu_align_decode
    import lsu_align_pkg::*;
(
    input  logic [OFFW-1:0]  off,
    input  logic [1:0]       size,
    input  logic [1:0]       op,
    input  logic             cacheable,
    input  logic             wthru,
    input  logic             xlate,
    output logic [BYTES-1:0] be_lo,
    output logic [BYTES-1:0] be_hi,
    output logic             split,
    output logic             fault
);
    localparam int WIN = 2 * BYTES;

    logic [OFFW:0]    nbytes;
    logic [WIN-1:0]   span;
    logic             is_data;

    always_comb begin
        nbytes  = (OFFW+1)'(1) << size;
        // contiguous run of enables over a two-word window
        span    = ((WIN'(1) << nbytes) - WIN'(1)) << off;
        is_data = (op == OP_LOAD) || (op == OP_STORE);
        be_lo   = is_data ? span[BYTES-1:0]   : '0;
        be_hi   = is_data ? span[WIN-1:BYTES] : '0;
        split   = |be_hi;
        // attribute fault: independent of address and of byte order
        fault   = (op == OP_ZERO) && !xlate && (!cacheable || wthru);
    end
endmodule

// File: rtl/lsu_align_lanes.sv
`timescale 1ns/1ps
module lsu_align_lanes
    import lsu_align_pkg::*;
(
    input  logic [OFFW-1:0] off,
    input  logic [1:0]      size,
    input  logic            le,
    input  logic [DW-1:0]   st_val,
    input  logic [DW-1:0]   lo_word,
    input  logic [DW-1:0]   hi_word,
    output logic [DW-1:0]   st_lo,
    output logic [DW-1:0]   st_hi,
    output logic [DW-1:0]   ld_val
);
    localparam int WW = 2 * DW;

    logic [OFFW:0]   nbytes;
    logic [OFFW+2:0] lsh;
    logic [OFFW+3:0] rsh;
    logic [DW-1:0]   keep;
    logic [DW-1:0]   st_m, st_rev, st_ord;
    logic [WW-1:0]   st_win, ld_win;
    logic [DW-1:0]   ld_m, ld_rev;

    // full-word byte reversal, fixed wiring
    for (genvar g = 0; g < BYTES; g++) begin : g_rev
        assign st_rev[8*g +: 8] = st_m[8*(BYTES-1-g) +: 8];
        assign ld_rev[8*g +: 8] = ld_m[8*(BYTES-1-g) +: 8];
    end

    always_comb begin
        nbytes = (OFFW+1)'(1) << size;
        lsh    = {off, 3'b000};
        rsh    = {(OFFW+1)'(BYTES) - nbytes, 3'b000};
        keep   = (DW'(1) << {nbytes, 3'b000}) - DW'(1);
        if (nbytes == (OFFW+1)'(BYTES)) begin
            keep = '1;
        end

        // store: order the value bytes by address, then slide into the window
        st_m   = st_val & keep;
        st_ord = le ? st_m : (st_rev >> rsh);
        st_win = {{DW{1'b0}}, st_ord} << lsh;
        st_lo  = st_win[DW-1:0];
        st_hi  = st_win[WW-1:DW];

        // load: pull the access bytes out of the two-word window
        ld_win = {hi_word, lo_word} >> lsh;
        ld_m   = ld_win[DW-1:0] & keep;
        ld_val = le ? ld_m : (ld_rev >> rsh);
    end
endmodule

// File: rtl/lsu_align_split.sv
`timescale 1ns/1ps
module lsu_align_split
    import lsu_align_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LINE_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            attr_cacheable,
    input  logic            attr_wthru,
    input  logic            attr_le,
    input  logic            attr_xlate,
    output logic            bus_valid,
    input  logic            bus_ready,
    output logic [1:0]      bus_op,
    output logic [AW-1:0]   bus_addr,
    output logic [BYTES-1:0] bus_be,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic            done,
    output logic            exc,
    output logic [DW-1:0]   rdata
);
    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   addr;
        logic [1:0]      op;
        logic [1:0]      size;
        logic [DW-1:0]   wval;
        logic            le;
        logic            cach;
        logic            wthru;
        logic            xlate;
        logic [DW-1:0]   lo;
        logic [DW-1:0]   hi;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_IDLE, default: '0};

    regs_t q, d;

    logic [BYTES-1:0] be_lo, be_hi;
    logic             split, fault;
    logic [DW-1:0]    st_lo, st_hi, ld_val;
    logic [AW-1:0]    word_addr, line_addr;
    logic             is_cache;

    lsu_align_decode u_decode (
        .off       (q.addr[OFFW-1:0]),
        .size      (q.size),
        .op        (q.op),
        .cacheable (q.cach),
        .wthru     (q.wthru),
        .xlate     (q.xlate),
        .be_lo     (be_lo),
        .be_hi     (be_hi),
        .split     (split),
        .fault     (fault)
    );

    lsu_align_lanes u_lanes (
        .off     (q.addr[OFFW-1:0]),
        .size    (q.size),
        .le      (q.le),
        .st_val  (q.wval),
        .lo_word (q.lo),
        .hi_word (q.hi),
        .st_lo   (st_lo),
        .st_hi   (st_hi),
        .ld_val  (ld_val)
    );

    always_comb begin
        d         = q;
        req_ready = 1'b0;
        bus_valid = 1'b0;
        bus_op    = q.op;
        bus_addr  = '0;
        bus_be    = '0;
        bus_wdata = '0;
        done      = 1'b0;
        exc       = 1'b0;
        rdata     = '0;

        word_addr = {q.addr[AW-1:OFFW], {OFFW{1'b0}}};
        line_addr = {q.addr[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
        is_cache  = q.op[1];

        unique case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.st    = ST_BUS0;
                    d.addr  = req_addr;
                    d.op    = req_op;
                    d.size  = req_size;
                    d.wval  = req_wdata;
                    d.le    = attr_le;
                    d.cach  = attr_cacheable;
                    d.wthru = attr_wthru;
                    d.xlate = attr_xlate;
                    d.lo    = '0;
                    d.hi    = '0;
                end
            end
            ST_BUS0: begin
                if (fault) begin
                    exc  = 1'b1;
                    d.st = ST_IDLE;
                end else begin
                    bus_valid = 1'b1;
                    bus_addr  = is_cache ? line_addr : word_addr;
                    bus_be    = be_lo;
                    bus_wdata = (q.op == OP_STORE) ? st_lo : '0;
                    if (bus_ready) begin
                        d.lo = bus_rdata;
                        d.st = split ? ST_BUS1 : ST_RESP;
                    end
                end
            end
            ST_BUS1: begin
                bus_valid = 1'b1;
                bus_addr  = word_addr + AW'(BYTES);
                bus_be    = be_hi;
                bus_wdata = (q.op == OP_STORE) ? st_hi : '0;
                if (bus_ready) begin
                    d.hi = bus_rdata;
                    d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                done  = 1'b1;
                rdata = (q.op == OP_LOAD) ? ld_val : '0;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lsu_align_split_chk.sv
`timescale 1ns/1ps
module lsu_align_split_chk
    import lsu_align_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LINE_BITS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic [1:0]       bus_op,
    input logic [AW-1:0]    bus_addr,
    input logic [BYTES-1:0] bus_be,
    input logic [DW-1:0]    bus_wdata,
    input logic             done,
    input logic             exc
);
    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
                                    && $stable(bus_wdata) && $stable(bus_op));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    bus_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    // R8
    exc_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> !bus_valid && !done);

    // R8
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !exc && req_ready);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R2
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_op[1] |-> bus_addr[OFFW-1:0] == '0 && bus_be != '0);

    // R7
    line_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_op[1] |-> bus_addr[LINE_BITS-1:0] == '0 && bus_be == '0);

    // R3
    be_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_op[1] |-> $countones(bus_be + (bus_be & -bus_be)) <= 1);
endmodule

bind lsu_align_split lsu_align_split_chk #(.AW(AW), .LINE_BITS(LINE_BITS)) chk_i (.*);

// File: tb/lsu_align_split_test.sv
`timescale 1ns/1ps
module lsu_align_split_test;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        attr_cacheable = 1'b1, attr_wthru = 1'b0, attr_le = 1'b0, attr_xlate = 1'b0;
    logic        bus_valid, bus_ready = 1'b1;
    logic [1:0]  bus_op;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        done, exc;
    logic [31:0] rdata;

    always #4 clk = ~clk;

    lsu_align_split #(.AW(AW), .LINE_BITS(4)) uut (.*);

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hC3;
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = mbyte(bus_addr + 32'(k));
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-access observations
    int          ntx, n_done, n_exc;
    logic [31:0] t_addr [2];
    logic [3:0]  t_be   [2];
    logic [31:0] t_wd   [2];
    logic [1:0]  t_op   [2];
    logic [31:0] got_rd;
    int          last_ntx;
    logic [3:0]  last_be0, last_be1;
    bit          last_exc;

    task automatic access(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] addr,
                          input logic [31:0] wv, input bit ca, input bit wt, input bit le, input bit xl);
        bit acc = 0, acc_now, fin, ready_bad = 0;
        int cyc = 0;
        int n, off, e_ntx;
        logic [7:0]  m;
        logic [3:0]  e_be [2];
        logic [31:0] e_ad [2];
        logic [63:0] e_win;
        logic [31:0] e_rd;
        bit          e_exc;
        req_op = op; req_size = sz; req_addr = addr; req_wdata = wv;
        attr_cacheable = ca; attr_wthru = wt; attr_le = le; attr_xlate = xl;
        req_valid = 1'b1;
        ntx = 0; n_done = 0; n_exc = 0; got_rd = '0;
        forever begin
            @(negedge clk);
            acc_now = req_valid && req_ready;
            if (acc && req_ready) ready_bad = 1;
            if (bus_valid && bus_ready) begin
                if (ntx < 2) begin
                    t_addr[ntx] = bus_addr; t_be[ntx] = bus_be;
                    t_wd[ntx] = bus_wdata; t_op[ntx] = bus_op;
                end
                ntx++;
            end
            if (done) begin n_done++; got_rd = rdata; end
            if (exc) n_exc++;
            fin = (done || exc) && acc;
            @(posedge clk); #1;
            if (acc_now) begin req_valid = 1'b0; acc = 1; end
            bus_ready = ($urandom % 4) != 0;
            if (fin) break;
            if (++cyc > 60) begin chk(0, "R9 access never completed", 64'(cyc), 0); break; end
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready returns after completion", 64'(req_ready), 1);
        @(posedge clk); #1;

        // expected values from the requirements
        n = 1 << sz; off = int'(addr[1:0]);
        e_exc = (op == 2'd3) && !xl && (!ca || wt);
        e_rd = '0; e_win = '0;
        e_be[0] = '0; e_be[1] = '0;
        e_ad[0] = {addr[31:2], 2'b00}; e_ad[1] = e_ad[0] + 32'd4;
        if (op < 2) begin
            e_ntx = (off + n > 4) ? 2 : 1;
            m = 8'(((1 << n) - 1) << off);
            e_be[0] = m[3:0]; e_be[1] = m[7:4];
            for (int i = 0; i < n; i++) begin
                if (op == 2'd1)
                    e_win[8*(off+i) +: 8] = le ? wv[8*i +: 8] : wv[8*(n-1-i) +: 8];
                if (op == 2'd0) begin
                    if (le) e_rd[8*i +: 8] = mbyte(addr + 32'(i));
                    else    e_rd[8*(n-1-i) +: 8] = mbyte(addr + 32'(i));
                end
            end
        end else begin
            e_ntx = e_exc ? 0 : 1;
            e_ad[0] = {addr[31:4], 4'b0000};
        end

        chk(n_exc == (e_exc ? 1 : 0), op == 2'd3 ? "R8 exception count" : "R1 no exception", 64'(n_exc), 64'(e_exc));
        chk(ntx == e_ntx, op < 2 ? "R1 transaction count" : (e_exc ? "R8 no transaction" : "R7 one transaction"),
            64'(ntx), 64'(e_ntx));
        chk(n_done == (e_exc ? 0 : 1), "R5 done pulse count", 64'(n_done), 64'(!e_exc));
        chk(!ready_bad, "R9 ready low while busy", 64'(ready_bad), 0);
        for (int t = 0; t < 2; t++) begin
            if (t < ntx && t < e_ntx) begin
                chk(t_addr[t] == e_ad[t], op < 2 ? "R2 address" : "R7 line address", 64'(t_addr[t]), 64'(e_ad[t]));
                chk(t_op[t] == op, "R2 bus op", 64'(t_op[t]), 64'(op));
                chk(t_be[t] == e_be[t], op < 2 ? "R3 byte enables" : "R7 no enables", 64'(t_be[t]), 64'(e_be[t]));
                chk(t_wd[t] == e_win[32*t +: 32], "R4 store lanes", 64'(t_wd[t]), 64'(e_win[32*t +: 32]));
            end
        end
        if (n_done == 1) chk(got_rd == e_rd, op == 2'd0 ? "R5 load result" : "R5 zero result", 64'(got_rd), 64'(e_rd));
        last_ntx = ntx; last_be0 = t_be[0]; last_be1 = (ntx > 1) ? t_be[1] : 4'h0; last_exc = (n_exc != 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int    pn;
        logic [3:0] b0, b1;
        bit    ex;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0 && exc == 1'b0,
            "R10 reset outputs", {req_ready, bus_valid, done, exc}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_valid == 1'b0, "R10 after reset", {req_ready, bus_valid}, 2'b10);
        @(posedge clk); #1;

        // directed: every size at every offset, both byte orders, loads and stores
        for (int sz = 0; sz < 3; sz++)
            for (int o = 0; o < 4; o++)
                for (int le = 0; le < 2; le++) begin
                    access(2'd1, 2'(sz), 32'h0000_1230 + 32'(o), 32'hA1B2C3D4, 1, 0, le[0], 0);
                    access(2'd0, 2'(sz), 32'h0000_5674 + 32'(o), 32'h0, 1, 0, le[0], 0);
                end
        // boundary: crossing at the top of the address space wraps
        access(2'd0, 2'd2, 32'hFFFF_FFFE, 32'h0, 1, 0, 0, 0);
        // R7 cache control with odd low bits
        access(2'd2, 2'd0, 32'h0000_ABCF, 32'h0, 1, 0, 0, 0);
        access(2'd2, 2'd2, 32'h0000_0007, 32'h0, 0, 1, 1, 0);
        // R8 zero line across all attribute combinations
        for (int a = 0; a < 8; a++)
            access(2'd3, 2'd0, 32'h0000_4449, 32'h0, a[0], a[1], 0, a[2]);

        // R6 byte order leaves enables, split and fault alone
        for (int k = 0; k < 6; k++) begin
            logic [31:0] ad = 32'h0000_2000 + 32'(k);
            logic [1:0]  s2 = 2'(k % 3);
            access(2'd1, s2, ad, 32'h11223344, 1, 0, 0, 0);
            pn = last_ntx; b0 = last_be0; b1 = last_be1;
            access(2'd1, s2, ad, 32'h11223344, 1, 0, 1, 0);
            chk(pn == last_ntx && b0 == last_be0 && b1 == last_be1, "R6 endian keeps enables",
                {b1, b0, 8'(pn)}, {last_be1, last_be0, 8'(last_ntx)});
        end
        access(2'd3, 2'd0, 32'h0000_0010, 32'h0, 0, 0, 0, 0);
        ex = last_exc;
        access(2'd3, 2'd0, 32'h0000_0010, 32'h0, 0, 0, 1, 0);
        chk(ex == 1'b1 && last_exc == 1'b1, "R6 endian keeps fault", {ex, last_exc}, 2'b11);

        // random mix
        for (int r = 0; r < 400; r++) begin
            logic [3:0] at = 4'($urandom);
            access(2'($urandom % 4), 2'($urandom % 3), $urandom, $urandom,
                   at[0], at[1], at[2], at[3]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule